// File: doc/BRIEF.md
# Block-transfer request framing and response engine

This engine sits between the inbound and outbound message buffers of a block-transfer host interface and a command processor. When the register block signals that the host has finished writing a request, the engine reads the frame header from the inbound buffer and checks the declared length against the number of bytes written. It answers the interface-capability query by itself. Any other valid request goes to the command processor as a byte stream tagged with an 8-bit message id, and the engine keeps the request's sequence number.

When the processor returns a response with the current id, the engine writes the outbound frame and restores the saved sequence number in it. If the response would not fit the outbound buffer, it writes a short error frame instead. It then loads the outbound length and pulses three signals toward the register block: clear controller busy, set controller-to-host attention, and (when allowed) request an interrupt. All buffers are reached through plain address/data ports with combinational read data. The engine moves one byte per clock.

Top module: `bt_frame_engine`

## Requirements
- R1: After reset, `ob_we`, `fwd_valid`, `in_clr`, `busy_clr`, `atn_set`, `ob_len_we` and `irq_req` are low, and the message id on `fwd_id` is 0.
- R2: A request strobe with a byte count below 4 is ignored. It causes no inbound clear, no forward, no outbound write and no completion pulse.
- R3: For a request of 4 or more bytes, if byte 0 (the length byte) differs from the count minus 1, the engine pulses `in_clr` once. It does not forward the request, writes nothing and does not clear busy.
- R4: If byte 1 equals 0x18 and byte 3 equals 0x36, the engine writes this 10-byte reply to outbound addresses 0..9: 9, byte1|0x04, byte 2, 0x36, 0, 1, min(IN_DEPTH,255), min(OUT_DEPTH,255), 10, 0. It sets the outbound length to 10 and forwards nothing. Any other byte 1 or byte 3 value makes the request be forwarded.
- R5: A forwarded request appears on `fwd_data`, one byte per cycle with `fwd_valid` high. The stream is byte 1, then bytes 3 through count-1, so the sequence byte 2 is left out. `fwd_last` marks the final byte, and `fwd_id` carries the current message id.
- R6: A `rsp_start` whose `rsp_id` differs from the current id is ignored. Nothing is written and the id is unchanged.
- R7: An accepted response increments the message id by one, wrapping from 255 to 0.
- R8: A response of length L ≤ OUT_DEPTH-2 produces outbound bytes L+1, rsp[0], saved sequence, then rsp[1..L-1], with outbound length L+2.
- R9: A response of length L > OUT_DEPTH-2 produces the 5-byte frame 4, rsp[0], saved sequence, rsp[1], 0xCA, with outbound length 5.
- R10: On the cycle of the last outbound byte write, `ob_len_we`, `busy_clr` and `atn_set` pulse together for exactly one cycle.
- R11: `irq_req` pulses with the completion only when `irq_enable` is 1 and `irq_pending` is 0.
- R12: A request strobe or a response start that arrives while the engine is checking, replying, forwarding or building is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_go | input | 1 | Host has finished writing a request |
| req_count | input | CW | Number of bytes written to the inbound buffer |
| ib_addr | output | IAW | Inbound buffer read address |
| ib_data | input | 8 | Inbound buffer read data (combinational) |
| in_clr | output | 1 | Pulse: zero the inbound byte count |
| fwd_valid | output | 1 | Forwarded request byte valid |
| fwd_data | output | 8 | Forwarded request byte |
| fwd_last | output | 1 | Final byte of the forwarded request |
| fwd_id | output | 8 | Current message id |
| rsp_start | input | 1 | Processor has a response ready |
| rsp_id | input | 8 | Id the response belongs to |
| rsp_len | input | 8 | Response length in bytes |
| rsp_addr | output | 8 | Response buffer read address |
| rsp_data | input | 8 | Response buffer read data (combinational) |
| ob_we | output | 1 | Outbound buffer write enable |
| ob_addr | output | OAW | Outbound buffer write address |
| ob_wdata | output | 8 | Outbound buffer write data |
| ob_len_we | output | 1 | Load outbound length |
| ob_len | output | 8 | Outbound length value |
| busy_clr | output | 1 | Pulse: clear controller busy |
| atn_set | output | 1 | Pulse: set controller-to-host attention |
| irq_pending | input | 1 | Interrupt already pending |
| irq_enable | input | 1 | Interrupt enabled |
| irq_req | output | 1 | Pulse: raise the interrupt |

## Verification
Requests are sent with counts below four, with a length byte that disagrees with the count, with the exact capability header, and with near-miss headers that differ only in byte 1 or only in byte 3. Together these separate the ignore, discard, local-reply and forward paths. Responses are given with a wrong id, with lengths of exactly OUT_DEPTH-2 and one above it, and as a run of 256 accepted replies. These show the id gate, the oversize boundary and the 8-bit id wrap. Strobes placed in the middle of a local reply, and changes to the enable and pending inputs, show that busy periods drop new work and that the interrupt request is gated.

// File: rtl/bt_frame_engine.sv
module bt_frame_engine #(
  parameter int IN_DEPTH  = 64,
  parameter int OUT_DEPTH = 64,
  localparam int IAW = $clog2(IN_DEPTH),
  localparam int OAW = $clog2(OUT_DEPTH),
  localparam int CW  = $clog2(IN_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_go,
  input  logic [CW-1:0]  req_count,
  output logic [IAW-1:0] ib_addr,
  input  logic [7:0]     ib_data,
  output logic           in_clr,
  output logic           fwd_valid,
  output logic [7:0]     fwd_data,
  output logic           fwd_last,
  output logic [7:0]     fwd_id,
  input  logic           rsp_start,
  input  logic [7:0]     rsp_id,
  input  logic [7:0]     rsp_len,
  output logic [7:0]     rsp_addr,
  input  logic [7:0]     rsp_data,
  output logic           ob_we,
  output logic [OAW-1:0] ob_addr,
  output logic [7:0]     ob_wdata,
  output logic           ob_len_we,
  output logic [7:0]     ob_len,
  output logic           busy_clr,
  output logic           atn_set,
  input  logic           irq_pending,
  input  logic           irq_enable,
  output logic           irq_req
);

  localparam logic [7:0] APP_FN   = 8'h18;
  localparam logic [7:0] CAP_CMD  = 8'h36;
  localparam logic [7:0] CC_NOFIT = 8'hCA;
  localparam logic [7:0] IN_CAP   = 8'((IN_DEPTH  > 255) ? 255 : IN_DEPTH);
  localparam logic [7:0] OUT_CAP  = 8'((OUT_DEPTH > 255) ? 255 : OUT_DEPTH);
  localparam logic [8:0] MAX_RSP  = 9'(OUT_DEPTH - 2);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_LOCAL, S_FWD, S_WAIT, S_BUILD} st_t;

  st_t         st;
  logic [7:0]  idx, b0, b1, b2, seq, msg_id, rlen, last_idx;
  logic [CW-1:0] cnt;
  logic        over, len_bad, finish, open_st;
  logic [8:0]  cnt_m1;

  assign open_st = (st == S_IDLE) || (st == S_WAIT);
  assign cnt_m1  = 9'(cnt) - 9'd1;
  assign len_bad = {1'b0, b0} != cnt_m1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0;
      b0 <= '0; b1 <= '0; b2 <= '0; seq <= '0;
      msg_id <= '0; rlen <= '0; over <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_WAIT: begin
          if (rsp_start && rsp_id == msg_id) begin
            msg_id <= msg_id + 8'd1;
            rlen   <= rsp_len;
            over   <= {1'b0, rsp_len} > MAX_RSP;
            idx    <= '0;
            st     <= S_BUILD;
          end else if (req_go && req_count >= CW'(4)) begin
            cnt <= req_count;
            idx <= '0;
            st  <= S_CHECK;
          end
        end
        S_CHECK: begin
          idx <= idx + 8'd1;
          case (idx[1:0])
            2'd0: b0 <= ib_data;
            2'd1: b1 <= ib_data;
            2'd2: b2 <= ib_data;
            default: begin
              if (len_bad) st <= S_IDLE;
              else if (b1 == APP_FN && ib_data == CAP_CMD) begin
                idx <= '0;
                st  <= S_LOCAL;
              end else begin
                seq <= b2;
                idx <= 8'd2;
                st  <= S_FWD;
              end
            end
          endcase
        end
        S_FWD: begin
          idx <= idx + 8'd1;
          if (fwd_last) st <= S_WAIT;
        end
        S_LOCAL, S_BUILD: begin
          idx <= idx + 8'd1;
          if (finish) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ib_addr   = idx[IAW-1:0];
  assign in_clr    = (st == S_CHECK) && (idx == 8'd3) && len_bad;

  assign fwd_valid = (st == S_FWD);
  assign fwd_data  = (idx == 8'd2) ? b1 : ib_data;
  assign fwd_last  = fwd_valid && ({1'b0, idx} == cnt_m1);
  assign fwd_id    = msg_id;

  assign rsp_addr  = (idx < 8'd2) ? 8'd0 : idx - 8'd2;

  assign ob_we     = (st == S_LOCAL) || (st == S_BUILD);
  assign ob_addr   = idx[OAW-1:0];

  always_comb begin
    ob_wdata = 8'd0;
    if (st == S_LOCAL) begin
      case (idx)
        8'd0: ob_wdata = 8'd9;
        8'd1: ob_wdata = b1 | 8'h04;
        8'd2: ob_wdata = b2;
        8'd3: ob_wdata = CAP_CMD;
        8'd5: ob_wdata = 8'd1;
        8'd6: ob_wdata = IN_CAP;
        8'd7: ob_wdata = OUT_CAP;
        8'd8: ob_wdata = 8'd10;
        default: ob_wdata = 8'd0;
      endcase
    end else if (st == S_BUILD) begin
      if (idx == 8'd0)                 ob_wdata = over ? 8'd4 : rlen + 8'd1;
      else if (idx == 8'd2)            ob_wdata = seq;
      else if (over && idx == 8'd4)    ob_wdata = CC_NOFIT;
      else                             ob_wdata = rsp_data;
    end
  end

  assign last_idx  = (st == S_LOCAL) ? 8'd9 : (over ? 8'd4 : rlen + 8'd1);
  assign finish    = ob_we && (idx == last_idx);
  assign ob_len    = (st == S_LOCAL) ? 8'd10 : (over ? 8'd5 : rlen + 8'd2);
  assign ob_len_we = finish;
  assign busy_clr  = finish;
  assign atn_set   = finish;
  assign irq_req   = finish && irq_enable && !irq_pending;

  wire unused_ok = open_st;

endmodule

module bt_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rsp_start,
  input logic [7:0] rsp_id,
  input logic [7:0] fwd_id,
  input logic       fwd_valid,
  input logic       fwd_last,
  input logic       ob_we,
  input logic       ob_len_we,
  input logic       busy_clr,
  input logic       atn_set,
  input logic       irq_req,
  input logic       irq_enable,
  input logic       irq_pending,
  input logic       in_clr
);

  p_done_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ob_len_we |-> (busy_clr && atn_set && ob_we));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ob_len_we |=> !ob_len_we);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_enable && !irq_pending && busy_clr));

  p_discard_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_clr |-> (!ob_we && !fwd_valid && !busy_clr));

  p_last_in_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_last |-> fwd_valid);

  p_no_write_forwarding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !ob_we);

  p_stale_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_start && rsp_id != fwd_id) |=> $stable(fwd_id));

  p_id_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_id != $past(fwd_id)) |->
      (fwd_id == $past(fwd_id) + 8'd1) && $past(rsp_start) && ($past(rsp_id) == $past(fwd_id)));

endmodule

bind bt_frame_engine bt_frame_engine_chk u_chk (.*);

// File: tb/sim_bt_frame_engine.sv
`timescale 1ns/1ps
module sim_bt_frame_engine;
  localparam int IN_DEPTH  = 64;
  localparam int OUT_DEPTH = 64;
  localparam int IAW = $clog2(IN_DEPTH);
  localparam int OAW = $clog2(OUT_DEPTH);
  localparam int CW  = $clog2(IN_DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_go = 0, rsp_start = 0, irq_pending = 0, irq_enable = 1;
  logic [CW-1:0] req_count = '0;
  logic [7:0] rsp_id = 0, rsp_len = 0;
  logic [IAW-1:0] ib_addr;
  logic [7:0] ib_data, fwd_data, fwd_id, rsp_addr, rsp_data, ob_wdata, ob_len;
  logic in_clr, fwd_valid, fwd_last, ob_we, ob_len_we, busy_clr, atn_set, irq_req;
  logic [OAW-1:0] ob_addr;

  logic [7:0] ib_mem [IN_DEPTH];
  logic [7:0] rsp_mem [256];
  assign ib_data  = ib_mem[ib_addr];
  assign rsp_data = rsp_mem[rsp_addr];

  always #2 clk = ~clk;

  bt_frame_engine #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  int n_clr = 0, n_busy = 0, n_atn = 0, n_irq = 0, n_done = 0, n_ob = 0, n_fwd = 0;
  logic [7:0] last_len = 0;
  logic [7:0] exp_id = 0;
  string cur = "R1";
  logic [15:0] q_ob [$];
  logic [16:0] q_fwd [$];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (in_clr) n_clr++;
    if (busy_clr) n_busy++;
    if (atn_set) n_atn++;
    if (irq_req) n_irq++;
    if (ob_len_we) begin n_done++; last_len = ob_len; end
    if (ob_we) begin
      n_ob++;
      if (q_ob.size() == 0) check({cur, " unexpected write"}, {ob_addr, ob_wdata}, 0);
      else check({cur, " out byte"}, {8'(ob_addr), ob_wdata}, q_ob.pop_front());
    end
    if (fwd_valid) begin
      n_fwd++;
      if (q_fwd.size() == 0) check({cur, " unexpected forward"}, {fwd_id, fwd_last, fwd_data}, 0);
      else check({cur, " fwd byte"}, {fwd_id, fwd_last, fwd_data}, q_fwd.pop_front());
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired in %s actual=hung expected=done", cur);
    report();
  end

  task automatic send_req(input int n);
    @(posedge clk); #1 req_go = 1; req_count = CW'(n);
    @(posedge clk); #1 req_go = 0;
  endtask

  task automatic pulse_rsp(input logic [7:0] id, input logic [7:0] len);
    @(posedge clk); #1 rsp_start = 1; rsp_id = id; rsp_len = len;
    @(posedge clk); #1 rsp_start = 0;
  endtask

  task automatic settle(input int c);
    repeat (c) @(posedge clk);
    #1;
    check({cur, " scoreboard drained"}, q_ob.size() + q_fwd.size(), 0);
  endtask

  task automatic exp_local(input logic [7:0] fn, input logic [7:0] sq);
    logic [7:0] v [10];
    v = '{8'd9, fn | 8'h04, sq, 8'h36, 8'd0, 8'd1, 8'd64, 8'd64, 8'd10, 8'd0};
    for (int i = 0; i < 10; i++) q_ob.push_back({8'(i), v[i]});
  endtask

  task automatic exp_fwd(input int n);
    q_fwd.push_back({exp_id, 1'b0, ib_mem[1]});
    for (int i = 3; i < n; i++) q_fwd.push_back({exp_id, 1'(i == n - 1), ib_mem[i]});
  endtask

  task automatic exp_rsp(input int len, input logic [7:0] sq);
    for (int i = 0; i < 256; i++) rsp_mem[i] = 8'(i * 7 + 3);
    if (len > OUT_DEPTH - 2) begin
      q_ob.push_back({8'd0, 8'd4}); q_ob.push_back({8'd1, rsp_mem[0]});
      q_ob.push_back({8'd2, sq});   q_ob.push_back({8'd3, rsp_mem[1]});
      q_ob.push_back({8'd4, 8'hCA});
    end else begin
      q_ob.push_back({8'd0, 8'(len + 1)}); q_ob.push_back({8'd1, rsp_mem[0]});
      q_ob.push_back({8'd2, sq});
      for (int i = 3; i < len + 2; i++) q_ob.push_back({8'(i), rsp_mem[i - 2]});
    end
  endtask

  task automatic load(input logic [7:0] a, b, c, d, input int n);
    ib_mem[0] = a; ib_mem[1] = b; ib_mem[2] = c; ib_mem[3] = d;
    for (int i = 4; i < n; i++) ib_mem[i] = 8'(8'hA0 + i);
  endtask

  initial begin
    int c0, d0, i0;
    for (int i = 0; i < IN_DEPTH; i++) ib_mem[i] = 0;
    for (int i = 0; i < 256; i++) rsp_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values while held in reset and just after release
    check("R1 outputs quiet", {ob_we, fwd_valid, in_clr, busy_clr, atn_set, ob_len_we, irq_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 id zero", fwd_id, 0);

    cur = "R2";
    load(8'd2, 8'h18, 8'h01, 8'h36, 3);
    c0 = n_clr; d0 = n_done;
    send_req(3);
    settle(30);
    check("R2 short frame no clear", n_clr - c0, 0);
    check("R2 short frame no reply", n_done - d0, 0);

    cur = "R3";
    load(8'd7, 8'h18, 8'h02, 8'h36, 5);
    c0 = n_clr; d0 = n_busy;
    send_req(5);
    settle(30);
    check("R3 mismatch clears once", n_clr - c0, 1);
    check("R3 busy kept", n_busy - d0, 0);

    cur = "R4";
    load(8'd3, 8'h18, 8'h55, 8'h36, 4);
    exp_local(8'h18, 8'h55);
    d0 = n_done; i0 = n_irq; c0 = n_atn;
    send_req(4);
    settle(40);
    check("R4 reply length", last_len, 10);
    check("R10 one completion", n_done - d0, 1);
    check("R10 attention pulse", n_atn - c0, 1);
    check("R11 irq raised when enabled", n_irq - i0, 1);

    cur = "R11";
    irq_pending = 1;
    load(8'd3, 8'h18, 8'h56, 8'h36, 4);
    exp_local(8'h18, 8'h56);
    i0 = n_irq;
    send_req(4);
    settle(40);
    check("R11 no irq when pending", n_irq - i0, 0);
    irq_pending = 0;

    cur = "R5";
    load(8'd5, 8'h1C, 8'h21, 8'h36, 6);
    exp_fwd(6);
    send_req(6);
    settle(30);
    load(8'd3, 8'h18, 8'h22, 8'h37, 4);
    exp_fwd(4);
    d0 = n_done;
    send_req(4);
    settle(30);
    check("R4 near miss not answered locally", n_done - d0, 0);

    cur = "R6";
    d0 = n_ob;
    pulse_rsp(8'd5, 8'd4);
    settle(30);
    check("R6 stale response writes nothing", n_ob - d0, 0);

    cur = "R8";
    exp_rsp(4, 8'h22);
    pulse_rsp(exp_id, 8'd4);
    exp_id++;
    settle(30);
    check("R8 outbound length", last_len, 6);

    cur = "R8";
    load(8'd3, 8'h20, 8'h31, 8'h01, 4);
    exp_fwd(4);
    send_req(4);
    settle(20);
    exp_rsp(62, 8'h31);
    pulse_rsp(exp_id, 8'd62);
    exp_id++;
    settle(90);
    check("R8 boundary length", last_len, 64);

    cur = "R9";
    irq_enable = 0;
    load(8'd3, 8'h20, 8'h44, 8'h02, 4);
    exp_fwd(4);
    send_req(4);
    settle(20);
    exp_rsp(63, 8'h44);
    i0 = n_irq;
    pulse_rsp(exp_id, 8'd63);
    exp_id++;
    settle(30);
    check("R9 oversize length", last_len, 5);
    check("R11 no irq when disabled", n_irq - i0, 0);
    irq_enable = 1;

    cur = "R12";
    load(8'd3, 8'h18, 8'h77, 8'h36, 4);
    exp_local(8'h18, 8'h77);
    d0 = n_done; c0 = n_clr;
    send_req(4);
    repeat (5) @(posedge clk);
    send_req(4);
    pulse_rsp(exp_id, 8'd2);
    settle(50);
    check("R12 strobes during reply ignored", n_done - d0, 1);
    check("R12 no stray clear", n_clr - c0, 0);

    cur = "R7";
    d0 = n_done;
    for (int k = 0; k < 256; k++) begin
      exp_rsp(1, 8'h44);
      pulse_rsp(exp_id, 8'd1);
      exp_id++;
      repeat (4) @(posedge clk);
    end
    settle(10);
    check("R7 all 256 accepted", n_done - d0, 256);
    load(8'd4, 8'h2C, 8'h09, 8'h05, 5);
    exp_fwd(5);
    send_req(5);
    settle(30);
    check("R7 id after wrap", fwd_id, exp_id);

    report();
  end
endmodule